// File: doc/BRIEF.md
# Serial Flash Write Guard

This block is the command-gating and write-protection core of a serial NOR flash device. It watches the chip-select, serial clock and serial data lines and assembles opcode, address and status bytes from them. It also holds the write enable latch, the two block-protect bits and the status-register write-disable bit. It decides whether each program, erase or status-write command may go ahead. Program and erase requests that it grants go to the memory back end as a one-cycle request that carries an operation code and a 24-bit address. The back end answers later with a one-cycle done pulse.

The serial lines are sampled with the block's own clock. The serial clock must therefore run at a fraction of that clock. Every decision is taken on the cycle after chip select goes high, and only if the frame ended on a whole byte. A read-status command streams the live status byte out on the serial output for as long as chip select stays low. The release command returns a fixed signature byte after three dummy bytes.

Top module: `spi_flash_wguard`

## Requirements
- R1: After reset, the write enable latch, write-in-progress and deep power-down are all clear, the protection bits are zero, no request is issued and a status read returns 0x00.
- R2: Opcode 0x06 sets the write enable latch. The modifying commands are status write 0x01, program 0x02, sector erase 0x20, block erase 0xD8, and chip erase 0x60 or 0xC7. A modifying command runs only while the latch is set. A refused command leaves the latch unchanged.
- R3: Opcode 0x04 clears the write enable latch. An accepted status write clears the latch at once. For a granted program or erase, the latch and write-in-progress both stay set until the done pulse and clear together on it.
- R4: A frame is acted on only when chip select rises after a whole number of bytes. Status write needs at least 2 bytes, and program, sector erase and block erase need at least 4. Other commands need at least 1 byte, and extra bytes are ignored.
- R5: The block-protect bits are status bits 3:2 and act on address bits 17:16. The codes are: 0 protects nothing, 1 protects the quarter where bits 17:16 are 11, 2 protects the half where bit 17 is 1, and 3 protects everything. A program or erase that hits a protected region is refused. Chip erase is refused whenever the bits are non-zero.
- R6: A status write stores status bits 7, 3 and 2 from its second byte. While status bit 7 is set and wp_n is low, a status write is refused, and the protection bits and bit 7 keep their values.
- R7: Until PUW_CYCLES clocks have passed since reset, every modifying command is refused.
- R8: A granted command pulses mem_req for one cycle. mem_op is 0 for program, 1 for sector erase, 2 for block erase and 3 for chip erase. mem_addr carries the 24-bit command address, or 0 for chip erase. While write-in-progress is set, every command except read status is ignored.
- R9: Opcode 0xB9 enters deep power-down. There, every command is ignored except 0xAB, which leaves it. A status read returns zeros while in deep power-down.
- R10: Opcode 0x05 returns the status byte MSB first in each byte after the opcode. The byte is {bit7 write-disable, 000, protect[1:0], latch, in-progress}. It is refreshed at each byte boundary. spi_miso is 0 while chip select is high.
- R11: Opcode 0xAB returns SIG_BYTE in every byte after three dummy bytes, unless write-in-progress is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial lines are sampled on it |
| rst_n | input | 1 | Active-low power-on reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out |
| wp_n | input | 1 | Active-low write-protect pin |
| mem_req | output | 1 | One-cycle grant toward the back end |
| mem_op | output | 2 | Granted operation code |
| mem_addr | output | 24 | Granted address |
| mem_done | input | 1 | One-cycle completion from the back end |

## Verification
The bench first goes after the partial frames: chip select rising a few bits into a byte, and commands one byte short. A design that counted bytes loosely would grant an erase or set the latch from a truncated frame. It then aims at the protection edges: addresses just inside and just outside each protected quarter and half, chip erase with any non-zero protect code, and a status write with the write-protect pin low while bit 7 is set. A weak decoder would erase protected space or let the lock be lifted. Commands sent during a busy period, during deep power-down and during the power-up window expose a design that clears the latch on a refused command, or that serves writes it should ignore. Random command streams, with random pin levels and done timing, are then checked against a bench model after every frame.

// File: rtl/spi_flash_wguard_pkg.sv
package spi_flash_wguard_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 3;

    localparam logic [7:0] OP_SET_WEL  = 8'h06;
    localparam logic [7:0] OP_CLR_WEL  = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_PROGRAM  = 8'h02;
    localparam logic [7:0] OP_ERASE_S  = 8'h20;
    localparam logic [7:0] OP_ERASE_B  = 8'hD8;
    localparam logic [7:0] OP_ERASE_C1 = 8'h60;
    localparam logic [7:0] OP_ERASE_C2 = 8'hC7;
    localparam logic [7:0] OP_SLEEP    = 8'hB9;
    localparam logic [7:0] OP_WAKE     = 8'hAB;

    typedef enum logic [1:0] {
        MOP_PROG  = 2'd0,
        MOP_SECT  = 2'd1,
        MOP_BLOCK = 2'd2,
        MOP_CHIP  = 2'd3
    } mem_op_e;

    typedef struct packed {
        logic              sck_q;
        logic              cs_q;
        logic [BYTE_W-2:0] shreg;
        logic [BIT_CW-1:0] bitcnt;
        logic              bit_tick;
        logic              byte_tick;
        logic [BYTE_W-1:0] byte_data;
        logic              frame_start;
        logic              frame_end;
        logic              frame_aligned;
    } rx_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]  nbytes;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic              wel;
        logic              wip;
        logic              dpd;
        logic              srwd;
        logic [1:0]        bp;
        logic              mem_req;
        logic [1:0]        mem_op;
        logic [ADDR_W-1:0] mem_addr;
    } ctl_state_t;

    // Region check: top2 is the two most significant array address bits.
    function automatic logic region_locked(input logic [1:0] bp,
                                           input logic       whole,
                                           input logic [1:0] top2);
        logic hit;
        if (whole) begin
            hit = (bp != 2'd0);
        end else begin
            case (bp)
                2'd0:    hit = 1'b0;
                2'd1:    hit = (top2 == 2'b11);
                2'd2:    hit = top2[1];
                default: hit = 1'b1;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/sfw_spi_rx.sv
module sfw_spi_rx
    import spi_flash_wguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              bit_tick,
    output logic              byte_tick,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_aligned
);

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    rx_state_t rx_q, rx_d;

    always_comb begin
        rx_d             = rx_q;
        rx_d.sck_q       = sck;
        rx_d.cs_q        = cs_n;
        rx_d.bit_tick    = 1'b0;
        rx_d.byte_tick   = 1'b0;
        rx_d.frame_start = 1'b0;
        rx_d.frame_end   = 1'b0;

        if (!cs_n && rx_q.cs_q) begin
            rx_d.bitcnt      = '0;
            rx_d.frame_start = 1'b1;
        end else if (!cs_n && sck && !rx_q.sck_q) begin
            rx_d.shreg    = {rx_q.shreg[BYTE_W-3:0], mosi};
            rx_d.bit_tick = 1'b1;
            rx_d.bitcnt   = rx_q.bitcnt + 1'b1;
            if (rx_q.bitcnt == LAST_BIT) begin
                rx_d.byte_tick = 1'b1;
                rx_d.byte_data = {rx_q.shreg, mosi};
            end
        end

        if (cs_n && !rx_q.cs_q) begin
            rx_d.frame_end     = 1'b1;
            rx_d.frame_aligned = (rx_q.bitcnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.cs_q <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign bit_tick      = rx_q.bit_tick;
    assign byte_tick     = rx_q.byte_tick;
    assign byte_data     = rx_q.byte_data;
    assign frame_start   = rx_q.frame_start;
    assign frame_end     = rx_q.frame_end;
    assign frame_aligned = rx_q.frame_aligned;

endmodule

// File: rtl/sfw_spi_tx.sv
module sfw_spi_tx
    import spi_flash_wguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              miso
);

    logic [BYTE_W-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (load) begin
            sh_d = load_data;
        end else if (shift) begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso = cs_n ? 1'b0 : sh_q[BYTE_W-1];

endmodule

// File: rtl/sfw_puw_timer.sv
module sfw_puw_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          exp_q, exp_d;

    always_comb begin
        cnt_d = cnt_q;
        exp_d = exp_q;
        if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
        if (cnt_d == LIMIT) exp_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            exp_q <= exp_d;
        end
    end

    assign expired = exp_q;

endmodule

// File: rtl/spi_flash_wguard.sv
module spi_flash_wguard
    import spi_flash_wguard_pkg::*;
#(
    parameter int         PUW_CYCLES = 1000,
    parameter int         MEM_AW     = 18,
    parameter logic [7:0] SIG_BYTE   = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wp_n,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done
);

    localparam int TOP_BIT = MEM_AW - 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] MIN_STAT = CNT_W'(2);
    localparam logic [CNT_W-1:0] MIN_ADDR = CNT_W'(4);
    localparam logic [CNT_W-1:0] SIG_IDX  = CNT_W'(3);

    logic              bit_tick, byte_tick, frame_start, frame_end, frame_aligned;
    logic [BYTE_W-1:0] rx_byte;
    logic              puw_done;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_data;

    ctl_state_t st_q, st_d;

    sfw_spi_rx u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (spi_cs_n),
        .sck           (spi_sck),
        .mosi          (spi_mosi),
        .bit_tick      (bit_tick),
        .byte_tick     (byte_tick),
        .byte_data     (rx_byte),
        .frame_start   (frame_start),
        .frame_end     (frame_end),
        .frame_aligned (frame_aligned)
    );

    sfw_puw_timer #(.CYCLES(PUW_CYCLES)) u_puw (
        .clk     (clk),
        .rst_n   (rst_n),
        .expired (puw_done)
    );

    sfw_spi_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .clear     (frame_start),
        .shift     (bit_tick),
        .load      (tx_load),
        .load_data (tx_data),
        .miso      (spi_miso)
    );

    // Response path: decide at each byte boundary what goes out next.
    always_comb begin
        logic [7:0] cur_op;
        cur_op  = (st_q.nbytes == '0) ? rx_byte : st_q.op;
        tx_load = 1'b0;
        tx_data = '0;
        if (byte_tick) begin
            if (cur_op == OP_RD_STAT && !st_q.dpd) begin
                tx_load = 1'b1;
                tx_data = {st_q.srwd, 3'b000, st_q.bp, st_q.wel, st_q.wip};
            end else if (cur_op == OP_WAKE && st_q.nbytes >= SIG_IDX && !st_q.wip) begin
                tx_load = 1'b1;
                tx_data = SIG_BYTE;
            end
        end
    end

    // Command state: byte capture, completion and frame-end decisions.
    always_comb begin
        logic       may_write;
        logic       hw_lock;
        logic [1:0] top2;

        st_d         = st_q;
        st_d.mem_req = 1'b0;
        may_write    = puw_done && st_q.wel;
        hw_lock      = st_q.srwd && !wp_n;
        top2         = st_q.addr[TOP_BIT -: 2];

        if (frame_start) st_d.nbytes = '0;

        if (byte_tick) begin
            case (st_q.nbytes)
                CNT_W'(0): st_d.op            = rx_byte;
                CNT_W'(1): st_d.addr[23:16]   = rx_byte;
                CNT_W'(2): st_d.addr[15:8]    = rx_byte;
                CNT_W'(3): st_d.addr[7:0]     = rx_byte;
                default:   ;
            endcase
            if (st_q.nbytes != CNT_MAX) st_d.nbytes = st_q.nbytes + 1'b1;
        end

        if (mem_done && st_q.wip) begin
            st_d.wip = 1'b0;
            st_d.wel = 1'b0;
        end

        if (frame_end && frame_aligned && st_q.nbytes != '0) begin
            if (st_q.dpd) begin
                if (st_q.op == OP_WAKE) st_d.dpd = 1'b0;
            end else if (!st_q.wip) begin
                case (st_q.op)
                    OP_SET_WEL: st_d.wel = 1'b1;
                    OP_CLR_WEL: st_d.wel = 1'b0;
                    OP_SLEEP:   st_d.dpd = 1'b1;
                    OP_WR_STAT: begin
                        if (st_q.nbytes >= MIN_STAT && may_write && !hw_lock) begin
                            st_d.srwd = st_q.addr[23];
                            st_d.bp   = st_q.addr[19:18];
                            st_d.wel  = 1'b0;
                        end
                    end
                    OP_PROGRAM, OP_ERASE_S, OP_ERASE_B: begin
                        if (st_q.nbytes >= MIN_ADDR && may_write &&
                            !region_locked(st_q.bp, 1'b0, top2)) begin
                            st_d.mem_req  = 1'b1;
                            st_d.wip      = 1'b1;
                            st_d.mem_addr = st_q.addr;
                            st_d.mem_op   = (st_q.op == OP_PROGRAM) ? MOP_PROG :
                                            (st_q.op == OP_ERASE_S) ? MOP_SECT : MOP_BLOCK;
                        end
                    end
                    OP_ERASE_C1, OP_ERASE_C2: begin
                        if (may_write && !region_locked(st_q.bp, 1'b1, top2)) begin
                            st_d.mem_req  = 1'b1;
                            st_d.wip      = 1'b1;
                            st_d.mem_addr = '0;
                            st_d.mem_op   = MOP_CHIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req  = st_q.mem_req;
    assign mem_op   = st_q.mem_op;
    assign mem_addr = st_q.mem_addr;

endmodule

// File: rtl/sfw_checker.sv
module sfw_checker
    import spi_flash_wguard_pkg::*;
#(
    parameter int MEM_AW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              mem_req,
    input logic [1:0]        mem_op,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_done,
    input logic              puw_done,
    input ctl_state_t        st
);

    // R2: a grant only appears with the latch still set and busy raised
    p_grant_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (st.wel && st.wip));

    // R3: completion clears both latch and busy
    p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st.wip && mem_done) |=> (!st.wel && !st.wip));

    // R5: no grant into a protected region
    p_no_locked_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !region_locked(st.bp, mem_op == 2'd3, mem_addr[MEM_AW-1 -: 2]));

    // R6: hardware lock freezes protection bits
    p_hw_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st.srwd && !wp_n) |=> ($stable(st.bp) && st.srwd));

    // R7: no grant before the power-up window closes
    p_puw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> puw_done);

    // R8: no new grant while a previous one is in flight
    p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !$past(st.wip));

    // R8: a grant is a single-cycle pulse
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9: deep power-down never coexists with a grant
    p_dpd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st.dpd |-> !mem_req);

endmodule

bind spi_flash_wguard sfw_checker #(.MEM_AW(MEM_AW)) u_sfw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .mem_req  (mem_req),
    .mem_op   (mem_op),
    .mem_addr (mem_addr),
    .mem_done (mem_done),
    .puw_done (puw_done),
    .st       (st_q)
);

// File: tb/spi_flash_wguard_bench.sv
`timescale 1ns/1ps
module spi_flash_wguard_bench;

    localparam int         PUW  = 1000;
    localparam logic [7:0] SIG  = 8'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, mem_done = 1'b0;
    logic        miso, mem_req;
    logic [1:0]  mem_op;
    logic [23:0] mem_addr;

    always #4 clk = ~clk;

    spi_flash_wguard #(.PUW_CYCLES(PUW), .MEM_AW(18), .SIG_BYTE(SIG)) u_spi_flash_wguard (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .wp_n(wp_n), .mem_req(mem_req), .mem_op(mem_op),
        .mem_addr(mem_addr), .mem_done(mem_done)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    int req_cnt = 0, exp_req = 0;
    logic [1:0]  last_op, exp_op;
    logic [23:0] last_addr, exp_addr;
    logic [7:0]  txb [8];
    logic [7:0]  rxb [8];

    // bench model
    logic m_wel, m_wip, m_dpd, m_srwd, m_puw;
    logic [1:0] m_bp;

    always @(negedge clk) if (mem_req) begin
        req_cnt++; last_op = mem_op; last_addr = mem_addr;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic locked(input logic [1:0] bp, input logic whole, input logic [23:0] a);
        if (whole) return bp != 2'd0;
        case (bp)
            2'd0: return 1'b0;
            2'd1: return a[17:16] == 2'b11;
            2'd2: return a[17];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return m_dpd ? 8'h00 : {m_srwd, 3'b000, m_bp, m_wel, m_wip};
    endfunction

    task automatic xfer(input int nbits);
        for (int k = 0; k < 8; k++) rxb[k] = 8'h00;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = txb[i/8][7-(i%8)];
            sck  = 1'b0;
            repeat (4) @(negedge clk);
            rxb[i/8][7-(i%8)] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        sck = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic model(input logic [7:0] op, input logic [23:0] a, input int nbits);
        int  nb;
        logic mw;
        nb = nbits / 8;
        mw = m_puw && m_wel;
        if (nbits % 8 != 0 || nb == 0) return;
        if (m_dpd) begin
            if (op == 8'hAB) m_dpd = 1'b0;
            return;
        end
        if (m_wip) return;
        case (op)
            8'h06: m_wel = 1'b1;
            8'h04: m_wel = 1'b0;
            8'hB9: m_dpd = 1'b1;
            8'h01: if (nb >= 2 && mw && !(m_srwd && !wp_n)) begin
                m_srwd = a[23]; m_bp = a[19:18]; m_wel = 1'b0;
            end
            8'h02, 8'h20, 8'hD8: if (nb >= 4 && mw && !locked(m_bp, 1'b0, a)) begin
                m_wip = 1'b1; exp_req++; exp_addr = a;
                exp_op = (op == 8'h02) ? 2'd0 : (op == 8'h20) ? 2'd1 : 2'd2;
            end
            8'h60, 8'hC7: if (mw && !locked(m_bp, 1'b1, a)) begin
                m_wip = 1'b1; exp_req++; exp_addr = 24'h0; exp_op = 2'd3;
            end
            default: ;
        endcase
    endtask

    task automatic send(input logic [7:0] op, input logic [23:0] a, input int nbits);
        txb[0] = op; txb[1] = a[23:16]; txb[2] = a[15:8]; txb[3] = a[7:0];
        for (int k = 4; k < 8; k++) txb[k] = 8'($urandom);
        xfer(nbits);
        model(op, a, nbits);
    endtask

    task automatic done_pulse();
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
        repeat (2) @(negedge clk);
        if (m_wip) begin m_wip = 1'b0; m_wel = 1'b0; end
    endtask

    task automatic rdsr(output logic [7:0] v);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
        xfer(24);
        v = rxb[1];
        if (rxb[2] !== rxb[1]) v = 8'hEE;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] s;
        rdsr(s);
        check({tag, " status"}, {24'h0, s}, {24'h0, exp_status()});
        check({tag, " reqs"}, req_cnt, exp_req);
        if (exp_req > 0) begin
            check({tag, " op"}, {30'h0, last_op}, {30'h0, exp_op});
            check({tag, " addr"}, {8'h0, last_addr}, {8'h0, exp_addr});
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        void'($urandom(32'd4242));
        m_wel = 0; m_wip = 0; m_dpd = 0; m_srwd = 0; m_bp = 0; m_puw = 0;
        exp_op = 0; exp_addr = 0; last_op = 0; last_addr = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 idle miso", {31'h0, miso}, 0);
        check("R1 no req", {31'h0, mem_req}, 0);
        rdsr(s);
        check("R1 status after reset", {24'h0, s}, 32'h00);

        // R7 power-up window refuses modifying commands
        send(8'h06, 0, 8);
        send(8'h20, 24'h001000, 32);
        check_all("R7 puw refuse");
        check("R7 wel kept", {24'h0, exp_status()}, 32'h02);
        repeat (PUW) @(negedge clk);
        m_puw = 1'b1;

        // R3 WRDI clears, R2 erase without latch refused
        send(8'h04, 0, 8);
        check_all("R3 wrdi");
        send(8'h20, 24'h001000, 32);
        check_all("R2 no latch");

        // R8 grant, busy behaviour, R3 completion
        send(8'h06, 0, 8);
        send(8'h20, 24'h001234, 32);
        check_all("R8 sector grant");
        check("R8 busy status", {24'h0, exp_status()}, 32'h03);
        send(8'h04, 0, 8);
        send(8'hD8, 24'h002000, 32);
        check_all("R8 busy ignores");
        done_pulse();
        check_all("R3 done clears");

        // R4 framing
        send(8'h06, 0, 7);
        check_all("R4 short bits");
        send(8'h06, 0, 9);
        check_all("R4 odd bits");
        send(8'h06, 0, 16);
        check_all("R4 extra byte ok");
        send(8'h02, 24'h000100, 24);
        check_all("R4 three byte program");
        send(8'h02, 24'h000100, 35);
        check_all("R4 off-boundary program");

        // R6 status write and R5 region decode
        send(8'h01, 24'h040000, 16);   // bp=1
        check_all("R6 wrsr bp1");
        send(8'h06, 0, 8);
        send(8'h02, 24'hFF0000, 40);
        check_all("R5 quarter locked");
        send(8'h02, 24'h020000, 32);
        check_all("R5 below quarter ok");
        done_pulse();
        send(8'h06, 0, 8);
        send(8'h01, 24'h080000, 16);   // bp=2
        send(8'h06, 0, 8);
        send(8'hD8, 24'h020000, 32);
        check_all("R5 half locked");
        send(8'hC7, 0, 8);
        check_all("R5 chip erase locked");
        send(8'hD8, 24'h01FFFF, 32);
        check_all("R5 lower half ok");
        done_pulse();
        send(8'h06, 0, 8);
        send(8'h01, 24'h000000, 16);
        send(8'h06, 0, 8);
        send(8'h60, 24'h123456, 8);
        check_all("R8 chip erase op");
        done_pulse();

        // R6 hardware lock
        send(8'h06, 0, 8);
        send(8'h01, 24'h800000, 16);
        wp_n = 1'b0;
        send(8'h06, 0, 8);
        send(8'h01, 24'h0C0000, 16);
        check_all("R6 hw locked");
        check("R6 lock value", {24'h0, exp_status()}, 32'h82);
        wp_n = 1'b1;
        send(8'h01, 24'h000000, 16);
        check_all("R6 unlocked");

        // R9 deep power-down, R11 signature
        send(8'h06, 0, 8);
        send(8'hB9, 0, 8);
        check_all("R9 dpd reads zero");
        send(8'h04, 0, 8);
        send(8'h20, 24'h000000, 32);
        txb[0] = 8'hAB; txb[1] = 0; txb[2] = 0; txb[3] = 0; txb[4] = 0; txb[5] = 0;
        xfer(48);
        model(8'hAB, 0, 48);
        check("R11 signature", {24'h0, rxb[4]}, {24'h0, SIG});
        check("R11 signature repeats", {24'h0, rxb[5]}, {24'h0, SIG});
        check_all("R9 release keeps wel");
        check("R9 wel survived", {24'h0, exp_status()}, 32'h02);

        // R10 live refresh within one read
        send(8'h20, 24'h000000, 32);
        txb[0] = 8'h05; txb[1] = 0; txb[2] = 0;
        fork
            xfer(24);
            begin repeat (100) @(negedge clk); mem_done = 1'b1; @(negedge clk); mem_done = 1'b0; end
        join
        m_wip = 0; m_wel = 0;
        check("R10 first byte busy", {24'h0, rxb[1]}, 32'h03);
        check("R10 refreshed byte", {24'h0, rxb[2]}, 32'h00);
        check("R10 idle miso", {31'h0, miso}, 0);

        // random stream
        for (int it = 0; it < 140; it++) begin
            logic [7:0] ops [14];
            logic [7:0] op;
            int nb, nbits;
            ops = '{8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'h60,
                    8'hC7, 8'hB9, 8'hAB, 8'h05, 8'h06, 8'h06, 8'hFF};
            op = ops[$urandom % 14];
            nb = (op == 8'h01) ? 2 : (op == 8'h02 || op == 8'h20 || op == 8'hD8) ? 4 : 1;
            nb = nb + int'($urandom % 2);
            if ($urandom % 8 == 0) nb = nb - 1;
            nbits = nb * 8;
            if ($urandom % 5 == 0) nbits = nbits + 1 + int'($urandom % 7);
            wp_n = ($urandom % 3) != 0;
            send(op, 24'($urandom), nbits);
            if (m_wip && ($urandom % 2 == 0)) done_pulse();
            check_all("R2 R5 R6 R8 random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule